// File: doc/BRIEF.md
# Row Hit Sub-Pattern Logger

This block sits at the end of a sensor row and turns a wide snapshot of 48 comparator hit flags into sparse words for a small local store. At each sample strobe it gates the flags through a serially loaded mask and latches them together with the current time code. It then walks the latched row as eight groups of six adjacent pixels, one group per fast clock, and keeps only those groups where two or more pixels fired.

Each kept group becomes one word holding the six-pixel pattern, the group number and the latched time code. Words go into a circular register bank of parameterised depth. A downstream reader watches the pointers and the empty flag, takes the word shown on the read port, and pulses a read request to move on. When the bank has no free slot, new qualifying groups are thrown away and a sticky overflow flag records the loss.

One sample window is nine fast clocks: one to latch, then eight group tests. With the default 17-bit time code, each word is 26 bits wide.

Top module: `row_group_logger`

## Requirements
- R1: After asynchronous reset (rst_n low) both pointers are 0, empty is 1, full is 0, overflow is 0, and every mask bit is 1 (all pixels enabled).
- R2: While mask_shift is 1 at a clock edge, the mask moves up one bit and mask_sdi enters bit 0. After 48 shifts, the first bit shifted in sits at pixel 47. A mask bit of 0 forces that pixel's flag to 0 before the latch.
- R3: A sample_go seen while the block is idle latches the masked flags and time_in at that edge (cycle 0). The next 8 edges test groups 0 to 7 in ascending order, one per edge, so a group g that qualifies is written at edge g+1.
- R4: A sample_go that arrives during the eight test cycles is ignored: it neither changes the latched row nor starts a new window.
- R5: Group g covers pixels 6g to 6g+5, and pattern bit k is pixel 6g+k. A group is stored only when at least 2 of its 6 masked flags are 1.
- R6: A stored word has pattern in bits [5:0], group ID in bits [8:6] and the latched time code in bits [25:9].
- R7: Each stored word goes to the slot at wr_ptr, and wr_ptr then advances by one, wrapping from DEPTH-1 (18) to 0.
- R8: When the bank holds DEPTH unread words, full is 1. A qualifying group is then dropped, overflow goes to 1 and wr_ptr is left unchanged.
- R9: Whenever empty is 0, rd_data shows the word at rd_ptr. A rd_req with empty at 0 advances rd_ptr by one modulo DEPTH. A rd_req with empty at 1 leaves rd_ptr unchanged.
- R10: overflow stays at 1 until reset, even after the bank has been drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, nine cycles per sample window |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_go | input | 1 | Sample strobe, periodic or from an external trigger |
| hit_in | input | 48 | Comparator hit flags of the row |
| time_in | input | 17 | Current time code |
| mask_shift | input | 1 | Shift-enable for the mask register |
| mask_sdi | input | 1 | Serial data into the mask register, 1 enables a pixel |
| rd_req | input | 1 | Pops the word at the read pointer |
| rd_data | output | 26 | Word at the read pointer |
| wr_ptr | output | 5 | Bank write pointer |
| rd_ptr | output | 5 | Bank read pointer |
| empty | output | 1 | No unread words in the bank |
| full | output | 1 | Bank holds DEPTH unread words |
| overflow | output | 1 | Sticky flag: a qualifying group was dropped |

## Verification
The bench uses rows where each group has exactly one hit, to catch a threshold of "at least one" that would flood the bank with single-pixel noise. It watches wr_ptr edge by edge after a strobe, to catch a design that latches one cycle late or scans the groups out of order. A second strobe in mid-scan checks that the design does not restart or overwrite the latched row, and a masked group with one pixel left checks the serial bit order and the pre-latch gating. Filling the bank past its depth checks three things: the words that arrive last are the ones dropped, the pointers wrap at 18 rather than at a power of two, and overflow survives a full drain.

// File: rtl/row_group_logger.sv
module row_group_logger #(
  parameter int NPIX  = 48,
  parameter int GRP   = 6,
  parameter int TW    = 17,
  parameter int DEPTH = 19,
  localparam int NGRP = NPIX / GRP,
  localparam int IDW  = $clog2(NGRP),
  localparam int PW   = $clog2(DEPTH),
  localparam int WW   = TW + IDW + GRP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_go,
  input  logic [NPIX-1:0] hit_in,
  input  logic [TW-1:0] time_in,
  input  logic          mask_shift,
  input  logic          mask_sdi,
  input  logic          rd_req,
  output logic [WW-1:0] rd_data,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic          empty,
  output logic          full,
  output logic          overflow
);

  logic [NPIX-1:0] mask, lat;
  logic [TW-1:0]   tlat;
  logic            scan;
  logic [IDW-1:0]  gidx;
  logic [PW:0]     cnt;
  logic [WW-1:0]   bank [DEPTH];

  logic [GRP-1:0] pat;
  assign pat = lat[gidx*GRP +: GRP];

  logic qual, do_wr, do_rd;
  assign qual  = scan && ($countones(pat) > 1);
  assign empty = (cnt == '0);
  assign full  = (cnt == (PW+1)'(DEPTH));
  assign do_wr = qual && !full;
  assign do_rd = rd_req && !empty;
  assign rd_data = bank[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mask <= '1;
    else if (mask_shift) mask <= {mask[NPIX-2:0], mask_sdi};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lat  <= '0;
      tlat <= '0;
      scan <= 1'b0;
      gidx <= '0;
    end else if (!scan) begin
      if (sample_go) begin
        lat  <= hit_in & mask;
        tlat <= time_in;
        scan <= 1'b1;
        gidx <= '0;
      end
    end else begin
      gidx <= gidx + 1'b1;
      if (gidx == IDW'(NGRP-1)) scan <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= nxt(wr_ptr);
      if (do_rd) rd_ptr <= nxt(rd_ptr);
      if (qual && full) overflow <= 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end

  always_ff @(posedge clk)
    if (do_wr) bank[wr_ptr] <= {tlat, gidx, pat};

  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R8
  drop_holds_wptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual && full) |=> ($stable(wr_ptr) && overflow));

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty) |=> $stable(rd_ptr));

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan && sample_go) |=> $stable(lat));

  // R7
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, wr_ptr} < (PW+1)'(DEPTH)) && ({1'b0, rd_ptr} < (PW+1)'(DEPTH)));

  // R8
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

endmodule

// File: tb/sim_row_group_logger.sv
module sim_row_group_logger;
  localparam int D = 19;

  logic clk = 0, rst_n = 0, sample_go = 0, mask_shift = 0, mask_sdi = 0, rd_req = 0;
  logic [47:0] hit_in = '0;
  logic [16:0] time_in = '0;
  logic [25:0] rd_data;
  logic [4:0]  wr_ptr, rd_ptr;
  logic        empty, full, overflow;

  row_group_logger u0 (.clk, .rst_n, .sample_go, .hit_in, .time_in, .mask_shift,
    .mask_sdi, .rd_req, .rd_data, .wr_ptr, .rd_ptr, .empty, .full, .overflow);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [47:0] bmask = '1;
  logic [25:0] q[$];
  int exp_wr = 0, exp_rd = 0;
  logic exp_ovf = 0;
  bit done = 0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic void model(logic [47:0] h, logic [16:0] t);
    logic [47:0] m = h & bmask;
    for (int g = 0; g < 8; g++) begin
      logic [5:0] p = m[g*6 +: 6];
      if ($countones(p) > 1) begin
        if (q.size() == D) exp_ovf = 1;
        else begin
          q.push_back({t, 3'(g), p});
          exp_wr = (exp_wr + 1) % D;
        end
      end
    end
  endfunction

  task automatic sample(logic [47:0] h, logic [16:0] t);
    @(negedge clk); sample_go = 1; hit_in = h; time_in = t;
    @(negedge clk); sample_go = 0; hit_in = '0;
    repeat (8) @(negedge clk);
    model(h, t);
  endtask

  task automatic pop_all(string r);
    while (q.size() > 0) begin
      chk(r, {31'd0, empty}, 0);
      chk(r, rd_data, q[0]);
      void'(q.pop_front());
      rd_req = 1; @(negedge clk); rd_req = 0;
      exp_rd = (exp_rd + 1) % D;
      chk(r, rd_ptr, exp_rd);
    end
    chk(r, {31'd0, empty}, 1);
  endtask

  task automatic t_reset;
    chk("R1 wr_ptr", wr_ptr, 0);
    chk("R1 rd_ptr", rd_ptr, 0);
    chk("R1 empty", {31'd0, empty}, 1);
    chk("R1 full", {31'd0, full}, 0);
    chk("R1 overflow", {31'd0, overflow}, 0);
  endtask

  task automatic t_basic;
    logic [47:0] h = '0;
    h[1:0] = 2'b11; h[8] = 1; h[23:18] = '1; h[47:46] = 2'b11;
    sample(h, 17'h1abcd);
    chk("R5 R1 stored count", wr_ptr, exp_wr);
    chk("R6 first word", rd_data, {17'h1abcd, 3'd0, 6'b000011});
    pop_all("R6 R9 basic");
  endtask

  task automatic t_single;
    logic [47:0] h = '0;
    for (int g = 0; g < 8; g++) h[g*6 + (g % 6)] = 1;
    sample(h, 17'h00042);
    chk("R5 single hits dropped wr_ptr", wr_ptr, exp_wr);
    chk("R5 single hits empty", {31'd0, empty}, 1);
  endtask

  task automatic t_order;
    logic [47:0] h = '0;
    int s = exp_wr;
    h[13:12] = 2'b11; h[35:33] = 3'b111;
    @(negedge clk); sample_go = 1; hit_in = h; time_in = 17'h7;
    @(negedge clk); sample_go = 0;
    @(negedge clk); @(negedge clk);
    chk("R3 before group2", wr_ptr, s);
    @(negedge clk);
    chk("R3 group2 at edge3", wr_ptr, (s + 1) % D);
    @(negedge clk); @(negedge clk);
    chk("R3 before group5", wr_ptr, (s + 1) % D);
    @(negedge clk);
    chk("R3 group5 at edge6", wr_ptr, (s + 2) % D);
    @(negedge clk); @(negedge clk);
    model(h, 17'h7);
    pop_all("R3 order");
  endtask

  task automatic t_ignore;
    logic [47:0] a = '0;
    a[5:4] = 2'b11;
    @(negedge clk); sample_go = 1; hit_in = a; time_in = 17'h11;
    @(negedge clk); sample_go = 0; hit_in = '0;
    @(negedge clk); @(negedge clk);
    sample_go = 1; hit_in = '1; time_in = 17'h22;
    @(negedge clk); sample_go = 0; hit_in = '0;
    repeat (14) @(negedge clk);
    model(a, 17'h11);
    chk("R4 mid-scan strobe ignored", wr_ptr, exp_wr);
    pop_all("R4 contents");
  endtask

  task automatic t_mask;
    logic [47:0] w = '1;
    logic [47:0] h = '0;
    w[0] = 0; w[1] = 0; w[47] = 0;
    for (int i = 47; i >= 0; i--) begin
      @(negedge clk); mask_shift = 1; mask_sdi = w[i];
    end
    @(negedge clk); mask_shift = 0;
    bmask = w;
    h[2:0] = 3'b111; h[7:6] = 2'b11; h[47:46] = 2'b11;
    sample(h, 17'h33);
    chk("R2 masked count", wr_ptr, exp_wr);
    chk("R2 group1 kept", rd_data, {17'h33, 3'd1, 6'b000011});
    pop_all("R2 mask");
    for (int i = 0; i < 48; i++) begin
      @(negedge clk); mask_shift = 1; mask_sdi = 1;
    end
    @(negedge clk); mask_shift = 0;
    bmask = '1;
  endtask

  task automatic t_full;
    sample('1, 17'h0a);
    sample('1, 17'h0b);
    sample('1, 17'h0c);
    chk("R8 full", {31'd0, full}, 1);
    chk("R8 overflow", {31'd0, overflow}, {31'd0, exp_ovf});
    chk("R7 R8 wr_ptr wrapped", wr_ptr, exp_wr);
    pop_all("R7 R9 drain");
    chk("R10 overflow sticky", {31'd0, overflow}, 1);
    rd_req = 1; @(negedge clk); rd_req = 0;
    chk("R9 empty read", rd_ptr, exp_rd);
    chk("R9 still empty", {31'd0, empty}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_single;
    t_order;
    t_ignore;
    t_mask;
    t_full;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule